// File: doc/BRIEF.md
# Peripheral Bridge Ordering Queues

This block stands between a system bus and a cluster of peripherals, some of which are DMA engines. Traffic headed for the devices is split by kind. Register read and write commands take one queue. Read data returning to the DMA engines takes a second queue. A slow register target can therefore hold up the command path without starving the DMA engines of their read data.

Traffic headed for the system bus is handled differently. DMA read requests, DMA write requests and responses to register reads all share a single first-in first-out queue. Because they share it, a register-read response can never overtake an earlier DMA request. A status read that reports completion always reaches the bus after the write it reports on. Responses from the slow generic expansion bus need no such ordering, so they have their own return queue.

A round-robin arbiter merges the shared queue and the expansion-bus queue onto the single upstream output. Every port uses a valid/ready handshake.

Top module: `pbq_bridge`

## Requirements
- R1: Register commands accepted at the `ds_cmd_*` port leave at the `dv_cmd_*` port in arrival order, with their write flag, source and data unchanged.
- R2: DMA read-return data goes through a queue of its own. It keeps being accepted and delivered while the register command queue is full and its output is stalled.
- R3: DMA requests and register-read responses leave at `sb_*` in the order they were accepted. `sb_kind` is 2'b00 for a DMA read request, 2'b01 for a DMA write request, 2'b10 for a register-read response and 2'b11 for a generic-bus response.
- R4: When a DMA request and a register-read response are offered in the same cycle, the DMA request is accepted and `up_rrsp_ready` is low, so the response takes the later slot.
- R5: Generic-bus responses use a separate return queue. `up_gen_ready` depends only on that queue's fill, so it stays high while the shared queue is full.
- R6: Each ingress ready is low exactly when its queue holds its configured depth, and a full queue takes no entry.
- R7: When the upstream output hands over an entry from one queue while the other queue holds an entry, the next entry offered comes from the other queue.
- R8: Once `sb_valid` is high and `sb_ready` is low, the same entry (kind, source and data) is offered until it is accepted.
- R9: After reset all queues are empty: every output valid is low and every ingress ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ds_cmd_valid | input | 1 | Register command offered from the system bus |
| ds_cmd_ready | output | 1 | Register command queue can accept |
| ds_cmd_write | input | 1 | 1 = register write, 0 = register read |
| ds_cmd_src | input | SW | Source identifier of the command |
| ds_cmd_data | input | DW | Command payload |
| dv_cmd_valid | output | 1 | Register command offered to the devices |
| dv_cmd_ready | input | 1 | Devices accept the command |
| dv_cmd_write | output | 1 | Write flag of the offered command |
| dv_cmd_src | output | SW | Source identifier of the offered command |
| dv_cmd_data | output | DW | Payload of the offered command |
| ds_rdat_valid | input | 1 | DMA read-return data offered from the system bus |
| ds_rdat_ready | output | 1 | Read-return queue can accept |
| ds_rdat_src | input | SW | Destination engine identifier |
| ds_rdat_data | input | DW | Read-return payload |
| dv_rdat_valid | output | 1 | Read-return data offered to the DMA engines |
| dv_rdat_ready | input | 1 | DMA engines accept the data |
| dv_rdat_src | output | SW | Engine identifier of the offered data |
| dv_rdat_data | output | DW | Offered read-return payload |
| up_dma_valid | input | 1 | DMA request offered by a device |
| up_dma_ready | output | 1 | Shared queue accepts the DMA request |
| up_dma_write | input | 1 | 1 = DMA write, 0 = DMA read |
| up_dma_src | input | SW | Requesting engine identifier |
| up_dma_data | input | DW | Request payload |
| up_rrsp_valid | input | 1 | Register-read response offered by a device |
| up_rrsp_ready | output | 1 | Shared queue accepts the response |
| up_rrsp_src | input | SW | Responding device identifier |
| up_rrsp_data | input | DW | Response payload |
| up_gen_valid | input | 1 | Generic-bus response offered |
| up_gen_ready | output | 1 | Generic return queue accepts |
| up_gen_src | input | SW | Generic-bus source identifier |
| up_gen_data | input | DW | Generic-bus response payload |
| sb_valid | output | 1 | Entry offered to the system bus |
| sb_ready | input | 1 | System bus accepts the entry |
| sb_kind | output | 2 | Entry type, encoded as in R3 |
| sb_src | output | SW | Source identifier of the entry |
| sb_data | output | DW | Entry payload |

## Verification
The sharpest corner is a DMA write followed by a register response, and also the two offered in the same cycle. A design that gave the shared queue two write ports, or let responses win a collision, would put the response on the bus ahead of the write.

The bench fills the register command queue and then stalls its output while read-return data keeps streaming. A design that shared storage or a ready signal between the two downstream paths would freeze the DMA data.

With the upstream output stalled, the bench fills the shared queue to the brim while feeding the generic-bus queue. A design that coupled the readies would refuse generic responses, and one whose grant moved during a stall would change the offered entry under a held valid. After release, the grants must alternate strictly between the two queues.

// File: rtl/pbq_pkg.sv
// Package: shared type definitions for the peripheral bridge queues.
// Assumes: a two-bit kind field rides with every upstream entry.
package pbq_pkg;

    // Type tag carried by each upstream entry; the system-bus side routes on it.
    typedef enum logic [1:0] {
        K_RD_REQ  = 2'b00,
        K_WR_REQ  = 2'b01,
        K_REG_RSP = 2'b10,
        K_GEN_RSP = 2'b11
    } up_kind_e;

endpackage

// File: rtl/pbq_fifo.sv
// Module: pbq_fifo
// Synchronous show-ahead FIFO with a valid/ready interface on both sides.
// An entry written at a clock edge is visible at the output from the next
// cycle. Ready is low only when the FIFO holds DEPTH entries; a pop in the
// same cycle does not free a slot for a push.
// Assumes: DEPTH >= 1; storage is not reset (contents are qualified by count).
module pbq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          push;
    logic          pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Status flags and handshake qualifiers.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        in_ready  = !full;
        out_valid = !empty;
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
        out_data  = mem[rd_ptr];
    end

    // Storage write; entries are only read once counted.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pbq_ord_merge.sv
// Module: pbq_ord_merge
// Steers DMA requests and register-read responses into the single write
// port of the shared ordered FIFO and tags each with its kind. One entry is
// taken per cycle; on a collision the DMA request wins, so a response can
// only ever land behind every request offered no later than itself.
// Assumes: fifo_ready reflects the shared FIFO's fill in the current cycle.
module pbq_ord_merge
    import pbq_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 4
) (
    input  logic             dma_valid,
    output logic             dma_ready,
    input  logic             dma_write,
    input  logic [SW-1:0]    dma_src,
    input  logic [DW-1:0]    dma_data,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [SW-1:0]    rsp_src,
    input  logic [DW-1:0]    rsp_data,
    output logic             wr_valid,
    input  logic             fifo_ready,
    output logic [2+SW+DW-1:0] wr_data
);

    up_kind_e dma_kind;

    // Selection and tagging of the entry written this cycle.
    always_comb begin
        dma_kind  = dma_write ? K_WR_REQ : K_RD_REQ;
        dma_ready = fifo_ready;
        rsp_ready = fifo_ready && !dma_valid;
        wr_valid  = dma_valid || rsp_valid;
        if (dma_valid) begin
            wr_data = {dma_kind, dma_src, dma_data};
        end else begin
            wr_data = {K_REG_RSP, rsp_src, rsp_data};
        end
    end

endmodule

// File: rtl/pbq_rr_arb.sv
// Module: pbq_rr_arb
// Two-way round-robin arbiter for the upstream output, one entry per grant.
// Source a is the shared ordered FIFO, source b the generic return queue.
// A grant offered without acceptance is locked until the entry is taken, so
// the output never changes under a held valid.
// Assumes: each source keeps its head entry until this arbiter pops it.
module pbq_rr_arb #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_valid,
    output logic         a_ready,
    input  logic [W-1:0] a_data,
    input  logic         b_valid,
    output logic         b_ready,
    input  logic [W-1:0] b_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic last_b;   // last granted source was b
    logic hold;     // a grant is locked while stalled
    logic hold_b;   // the locked grant points at b
    logic sel_b;
    logic fire;

    // Grant choice: locked grant, else alternate on contention, else whoever is valid.
    always_comb begin
        if (hold) begin
            sel_b = hold_b;
        end else if (a_valid && b_valid) begin
            sel_b = !last_b;
        end else begin
            sel_b = b_valid;
        end
        out_valid = a_valid || b_valid;
        out_data  = sel_b ? b_data : a_data;
        a_ready   = out_ready && !sel_b;
        b_ready   = out_ready && sel_b;
        fire      = out_valid && out_ready;
    end

    // Round-robin pointer and stall lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_b <= 1'b1;
            hold   <= 1'b0;
            hold_b <= 1'b0;
        end else if (fire) begin
            last_b <= sel_b;
            hold   <= 1'b0;
        end else if (out_valid) begin
            hold   <= 1'b1;
            hold_b <= sel_b;
        end
    end

endmodule

// File: rtl/pbq_bridge.sv
// Module: pbq_bridge (top)
// Peripheral bridge queues. Downstream: a register command queue and an
// independent DMA read-return queue. Upstream: one shared ordered FIFO for
// DMA requests and register-read responses, a separate return queue for the
// generic expansion bus, and a round-robin merge onto the system bus.
// Assumes: all ports use valid/ready; data transfers when both are high.
module pbq_bridge
    import pbq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int SW        = 4,
    parameter int CMD_DEPTH = 4,
    parameter int RDR_DEPTH = 4,
    parameter int ORD_DEPTH = 8,
    parameter int GEN_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ds_cmd_valid,
    output logic          ds_cmd_ready,
    input  logic          ds_cmd_write,
    input  logic [SW-1:0] ds_cmd_src,
    input  logic [DW-1:0] ds_cmd_data,
    output logic          dv_cmd_valid,
    input  logic          dv_cmd_ready,
    output logic          dv_cmd_write,
    output logic [SW-1:0] dv_cmd_src,
    output logic [DW-1:0] dv_cmd_data,
    input  logic          ds_rdat_valid,
    output logic          ds_rdat_ready,
    input  logic [SW-1:0] ds_rdat_src,
    input  logic [DW-1:0] ds_rdat_data,
    output logic          dv_rdat_valid,
    input  logic          dv_rdat_ready,
    output logic [SW-1:0] dv_rdat_src,
    output logic [DW-1:0] dv_rdat_data,
    input  logic          up_dma_valid,
    output logic          up_dma_ready,
    input  logic          up_dma_write,
    input  logic [SW-1:0] up_dma_src,
    input  logic [DW-1:0] up_dma_data,
    input  logic          up_rrsp_valid,
    output logic          up_rrsp_ready,
    input  logic [SW-1:0] up_rrsp_src,
    input  logic [DW-1:0] up_rrsp_data,
    input  logic          up_gen_valid,
    output logic          up_gen_ready,
    input  logic [SW-1:0] up_gen_src,
    input  logic [DW-1:0] up_gen_data,
    output logic          sb_valid,
    input  logic          sb_ready,
    output logic [1:0]    sb_kind,
    output logic [SW-1:0] sb_src,
    output logic [DW-1:0] sb_data
);

    localparam int CMD_W = 1 + SW + DW;
    localparam int RDR_W = SW + DW;
    localparam int ORD_W = 2 + SW + DW;
    localparam int GEN_W = SW + DW;

    logic             cmd_full, cmd_empty;
    logic             rdr_full, rdr_empty;
    logic             ord_full, ord_empty;
    logic             gen_full, gen_empty;
    logic             ord_wr_valid, ord_wr_ready;
    logic [ORD_W-1:0] ord_wr_data;
    logic             ord_valid, ord_pop;
    logic [ORD_W-1:0] ord_head;
    logic             gen_valid, gen_pop;
    logic [GEN_W-1:0] gen_head;
    logic [ORD_W-1:0] gen_tagged;
    logic [ORD_W-1:0] sb_entry;

    // Downstream register command queue.
    pbq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ds_cmd_valid),
        .in_ready  (ds_cmd_ready),
        .in_data   ({ds_cmd_write, ds_cmd_src, ds_cmd_data}),
        .out_valid (dv_cmd_valid),
        .out_ready (dv_cmd_ready),
        .out_data  ({dv_cmd_write, dv_cmd_src, dv_cmd_data}),
        .full      (cmd_full),
        .empty     (cmd_empty)
    );

    // Downstream DMA read-return queue, independent of the command queue.
    pbq_fifo #(.W(RDR_W), .DEPTH(RDR_DEPTH)) u_rdr_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ds_rdat_valid),
        .in_ready  (ds_rdat_ready),
        .in_data   ({ds_rdat_src, ds_rdat_data}),
        .out_valid (dv_rdat_valid),
        .out_ready (dv_rdat_ready),
        .out_data  ({dv_rdat_src, dv_rdat_data}),
        .full      (rdr_full),
        .empty     (rdr_empty)
    );

    // Steering of DMA requests and register responses into the ordered FIFO.
    pbq_ord_merge #(.DW(DW), .SW(SW)) u_merge (
        .dma_valid  (up_dma_valid),
        .dma_ready  (up_dma_ready),
        .dma_write  (up_dma_write),
        .dma_src    (up_dma_src),
        .dma_data   (up_dma_data),
        .rsp_valid  (up_rrsp_valid),
        .rsp_ready  (up_rrsp_ready),
        .rsp_src    (up_rrsp_src),
        .rsp_data   (up_rrsp_data),
        .wr_valid   (ord_wr_valid),
        .fifo_ready (ord_wr_ready),
        .wr_data    (ord_wr_data)
    );

    // Upstream shared ordered FIFO.
    pbq_fifo #(.W(ORD_W), .DEPTH(ORD_DEPTH)) u_ord_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ord_wr_valid),
        .in_ready  (ord_wr_ready),
        .in_data   (ord_wr_data),
        .out_valid (ord_valid),
        .out_ready (ord_pop),
        .out_data  (ord_head),
        .full      (ord_full),
        .empty     (ord_empty)
    );

    // Upstream generic expansion-bus return queue.
    pbq_fifo #(.W(GEN_W), .DEPTH(GEN_DEPTH)) u_gen_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (up_gen_valid),
        .in_ready  (up_gen_ready),
        .in_data   ({up_gen_src, up_gen_data}),
        .out_valid (gen_valid),
        .out_ready (gen_pop),
        .out_data  (gen_head),
        .full      (gen_full),
        .empty     (gen_empty)
    );

    // Tag generic-bus entries so the system bus can tell them apart.
    always_comb begin
        gen_tagged = {K_GEN_RSP, gen_head};
    end

    // Round-robin merge onto the system bus.
    pbq_rr_arb #(.W(ORD_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_valid   (ord_valid),
        .a_ready   (ord_pop),
        .a_data    (ord_head),
        .b_valid   (gen_valid),
        .b_ready   (gen_pop),
        .b_data    (gen_tagged),
        .out_valid (sb_valid),
        .out_ready (sb_ready),
        .out_data  (sb_entry)
    );

    // Split the granted entry onto the system-bus fields.
    always_comb begin
        {sb_kind, sb_src, sb_data} = sb_entry;
    end

endmodule

// File: rtl/pbq_bridge_chk.sv
// Module: pbq_bridge_chk
// Property checker bound to pbq_bridge; observes ports and queue flags.
// Assumes: synchronous active-low reset on rst_n.
module pbq_bridge_chk #(
    parameter int DW = 32,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ds_cmd_ready,
    input logic          ds_rdat_ready,
    input logic          up_dma_valid,
    input logic          up_dma_ready,
    input logic          up_rrsp_valid,
    input logic          up_rrsp_ready,
    input logic          up_gen_ready,
    input logic          sb_valid,
    input logic          sb_ready,
    input logic [1:0]    sb_kind,
    input logic [SW-1:0] sb_src,
    input logic [DW-1:0] sb_data,
    input logic          cmd_full,
    input logic          rdr_full,
    input logic          ord_full,
    input logic          ord_empty,
    input logic          gen_full
);

    // R6
    cmd_full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |-> !ds_cmd_ready);

    // R6
    ord_full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ord_full |-> (!up_dma_ready && !up_rrsp_ready));

    // R4
    dma_wins_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_dma_valid && up_rrsp_valid) |-> !up_rrsp_ready);

    // R2
    rdat_free_of_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_full && !rdr_full) |-> ds_rdat_ready);

    // R5
    gen_free_of_ord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_full && !gen_full) |-> up_gen_ready);

    // R8
    sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_ready) |=>
            (sb_valid && $stable(sb_kind) && $stable(sb_src) && $stable(sb_data)));

    // R7
    rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && sb_ready && sb_kind == 2'b11 && !ord_empty) |=>
            (sb_valid && sb_kind != 2'b11));

endmodule

bind pbq_bridge pbq_bridge_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ds_cmd_ready  (ds_cmd_ready),
    .ds_rdat_ready (ds_rdat_ready),
    .up_dma_valid  (up_dma_valid),
    .up_dma_ready  (up_dma_ready),
    .up_rrsp_valid (up_rrsp_valid),
    .up_rrsp_ready (up_rrsp_ready),
    .up_gen_ready  (up_gen_ready),
    .sb_valid      (sb_valid),
    .sb_ready      (sb_ready),
    .sb_kind       (sb_kind),
    .sb_src        (sb_src),
    .sb_data       (sb_data),
    .cmd_full      (cmd_full),
    .rdr_full      (rdr_full),
    .ord_full      (ord_full),
    .ord_empty     (ord_empty),
    .gen_full      (gen_full)
);

// File: tb/pbq_bridge_bench.sv
// Bench for pbq_bridge: behavioural queue model compared every cycle,
// plus directed phases for stall, ordering and round-robin corners.
module pbq_bridge_bench;

    localparam int DW = 32;
    localparam int SW = 4;
    localparam int CMD_D = 4;
    localparam int RDR_D = 4;
    localparam int ORD_D = 8;
    localparam int GEN_D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ds_cmd_valid, ds_cmd_ready, ds_cmd_write;
    logic [SW-1:0] ds_cmd_src;
    logic [DW-1:0] ds_cmd_data;
    logic          dv_cmd_valid, dv_cmd_ready, dv_cmd_write;
    logic [SW-1:0] dv_cmd_src;
    logic [DW-1:0] dv_cmd_data;
    logic          ds_rdat_valid, ds_rdat_ready;
    logic [SW-1:0] ds_rdat_src;
    logic [DW-1:0] ds_rdat_data;
    logic          dv_rdat_valid, dv_rdat_ready;
    logic [SW-1:0] dv_rdat_src;
    logic [DW-1:0] dv_rdat_data;
    logic          up_dma_valid, up_dma_ready, up_dma_write;
    logic [SW-1:0] up_dma_src;
    logic [DW-1:0] up_dma_data;
    logic          up_rrsp_valid, up_rrsp_ready;
    logic [SW-1:0] up_rrsp_src;
    logic [DW-1:0] up_rrsp_data;
    logic          up_gen_valid, up_gen_ready;
    logic [SW-1:0] up_gen_src;
    logic [DW-1:0] up_gen_data;
    logic          sb_valid, sb_ready;
    logic [1:0]    sb_kind;
    logic [SW-1:0] sb_src;
    logic [DW-1:0] sb_data;

    pbq_bridge #(.DW(DW), .SW(SW), .CMD_DEPTH(CMD_D), .RDR_DEPTH(RDR_D),
                 .ORD_DEPTH(ORD_D), .GEN_DEPTH(GEN_D)) u_pbq_bridge (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state.
    logic [1+SW+DW-1:0] q_cmd [$];
    logic [SW+DW-1:0]   q_rdr [$];
    logic [2+SW+DW-1:0] q_ord [$];
    logic [SW+DW-1:0]   q_gen [$];
    bit m_last_g = 1'b1;
    bit m_hold = 1'b0;
    bit m_hold_g = 1'b0;

    int fired_kinds [$];
    int stall_rdat = 0;
    int gen_while_full = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ds_cmd_valid = 0; ds_cmd_write = 0; ds_cmd_src = '0; ds_cmd_data = '0;
        dv_cmd_ready = 1;
        ds_rdat_valid = 0; ds_rdat_src = '0; ds_rdat_data = '0;
        dv_rdat_ready = 1;
        up_dma_valid = 0; up_dma_write = 0; up_dma_src = '0; up_dma_data = '0;
        up_rrsp_valid = 0; up_rrsp_src = '0; up_rrsp_data = '0;
        up_gen_valid = 0; up_gen_src = '0; up_gen_data = '0;
        sb_ready = 1;
    endtask

    task automatic random_inputs();
        ds_cmd_valid  = ($urandom_range(0, 99) < 50);
        ds_cmd_write  = 1'($urandom);
        ds_cmd_src    = SW'($urandom);
        ds_cmd_data   = $urandom;
        dv_cmd_ready  = ($urandom_range(0, 99) < 40);
        ds_rdat_valid = ($urandom_range(0, 99) < 50);
        ds_rdat_src   = SW'($urandom);
        ds_rdat_data  = $urandom;
        dv_rdat_ready = ($urandom_range(0, 99) < 60);
        up_dma_valid  = ($urandom_range(0, 99) < 40);
        up_dma_write  = 1'($urandom);
        up_dma_src    = SW'($urandom);
        up_dma_data   = $urandom;
        up_rrsp_valid = ($urandom_range(0, 99) < 40);
        up_rrsp_src   = SW'($urandom);
        up_rrsp_data  = $urandom;
        up_gen_valid  = ($urandom_range(0, 99) < 30);
        up_gen_src    = SW'($urandom);
        up_gen_data   = $urandom;
        sb_ready      = ($urandom_range(0, 99) < 65);
    endtask

    // Compare outputs with the model for the current cycle, then advance the model.
    task automatic step();
        bit e_cmd_rdy, e_rdr_rdy, e_dma_rdy, e_rsp_rdy, e_gen_rdy;
        bit ov, gv, selg, e_sb_valid;
        logic [2+SW+DW-1:0] e_sb;
        e_cmd_rdy = q_cmd.size() < CMD_D;
        e_rdr_rdy = q_rdr.size() < RDR_D;
        e_dma_rdy = q_ord.size() < ORD_D;
        e_rsp_rdy = e_dma_rdy && !up_dma_valid;
        e_gen_rdy = q_gen.size() < GEN_D;
        ov = q_ord.size() > 0;
        gv = q_gen.size() > 0;
        if (m_hold) selg = m_hold_g;
        else if (ov && gv) selg = !m_last_g;
        else selg = gv;
        e_sb_valid = ov || gv;
        e_sb = '0;
        if (e_sb_valid) e_sb = selg ? {2'b11, q_gen[0]} : q_ord[0];

        chk(ds_cmd_ready === e_cmd_rdy, "R6", "ds_cmd_ready", 64'(ds_cmd_ready), 64'(e_cmd_rdy));
        chk(dv_cmd_valid === (q_cmd.size() > 0), "R1", "dv_cmd_valid", 64'(dv_cmd_valid), 64'(q_cmd.size() > 0));
        if (q_cmd.size() > 0)
            chk({dv_cmd_write, dv_cmd_src, dv_cmd_data} === q_cmd[0], "R1", "dv_cmd entry",
                64'({dv_cmd_write, dv_cmd_src, dv_cmd_data}), 64'(q_cmd[0]));
        chk(ds_rdat_ready === e_rdr_rdy, "R2", "ds_rdat_ready", 64'(ds_rdat_ready), 64'(e_rdr_rdy));
        chk(dv_rdat_valid === (q_rdr.size() > 0), "R2", "dv_rdat_valid", 64'(dv_rdat_valid), 64'(q_rdr.size() > 0));
        if (q_rdr.size() > 0)
            chk({dv_rdat_src, dv_rdat_data} === q_rdr[0], "R2", "dv_rdat entry",
                64'({dv_rdat_src, dv_rdat_data}), 64'(q_rdr[0]));
        chk(up_dma_ready === e_dma_rdy, "R6", "up_dma_ready", 64'(up_dma_ready), 64'(e_dma_rdy));
        chk(up_rrsp_ready === e_rsp_rdy, "R4", "up_rrsp_ready", 64'(up_rrsp_ready), 64'(e_rsp_rdy));
        chk(up_gen_ready === e_gen_rdy, "R5", "up_gen_ready", 64'(up_gen_ready), 64'(e_gen_rdy));
        chk(sb_valid === e_sb_valid, "R7", "sb_valid", 64'(sb_valid), 64'(e_sb_valid));
        if (e_sb_valid)
            chk({sb_kind, sb_src, sb_data} === e_sb, "R3", "sb entry",
                64'({sb_kind, sb_src, sb_data}), 64'(e_sb));

        if (q_cmd.size() == CMD_D && !dv_cmd_ready && dv_rdat_ready && q_rdr.size() > 0) stall_rdat++;
        if (q_ord.size() == ORD_D && up_gen_valid && e_gen_rdy) gen_while_full++;

        // Model update for the coming edge.
        if (dv_cmd_ready && q_cmd.size() > 0) void'(q_cmd.pop_front());
        if (ds_cmd_valid && e_cmd_rdy) q_cmd.push_back({ds_cmd_write, ds_cmd_src, ds_cmd_data});
        if (dv_rdat_ready && q_rdr.size() > 0) void'(q_rdr.pop_front());
        if (ds_rdat_valid && e_rdr_rdy) q_rdr.push_back({ds_rdat_src, ds_rdat_data});
        if (e_sb_valid && sb_ready) begin
            fired_kinds.push_back(int'(e_sb[2+SW+DW-1 -: 2]));
            if (selg) void'(q_gen.pop_front());
            else void'(q_ord.pop_front());
            m_last_g = selg;
            m_hold = 1'b0;
        end else if (e_sb_valid) begin
            m_hold = 1'b1;
            m_hold_g = selg;
        end
        if (up_dma_valid && e_dma_rdy)
            q_ord.push_back({up_dma_write ? 2'b01 : 2'b00, up_dma_src, up_dma_data});
        else if (up_rrsp_valid && e_rsp_rdy)
            q_ord.push_back({2'b10, up_rrsp_src, up_rrsp_data});
        if (up_gen_valid && e_gen_rdy) q_gen.push_back({up_gen_src, up_gen_data});
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle_inputs();
            #1;
            step();
        end
    endtask

    // Watchdog: a hung run ends as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state at the ports.
        chk(!dv_cmd_valid && !dv_rdat_valid && !sb_valid, "R9", "valids after reset",
            64'({dv_cmd_valid, dv_rdat_valid, sb_valid}), 64'(0));
        chk(ds_cmd_ready && ds_rdat_ready && up_dma_ready && up_rrsp_ready && up_gen_ready,
            "R9", "readies after reset",
            64'({ds_cmd_ready, ds_rdat_ready, up_dma_ready, up_rrsp_ready, up_gen_ready}), 64'h1f);

        // Mixed random traffic on every port.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            random_inputs();
            #1;
            step();
        end
        run_idle(30);

        // R2: command path held full and stalled while read data streams.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            idle_inputs();
            dv_cmd_ready  = 0;
            ds_cmd_valid  = 1;
            ds_cmd_src    = SW'(i);
            ds_cmd_data   = 32'hC000_0000 + 32'(i);
            ds_rdat_valid = 1;
            ds_rdat_src   = SW'(i + 3);
            ds_rdat_data  = 32'hD000_0000 + 32'(i);
            #1;
            step();
        end
        chk(stall_rdat > 20, "R2", "rdat deliveries under cmd stall", 64'(stall_rdat), 64'(21));
        run_idle(30);

        // R3 and R4: write then response, then a same-cycle collision.
        fired_kinds.delete();
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            idle_inputs();
            sb_ready = (c >= 4);
            if (c == 0) begin
                up_dma_valid = 1; up_dma_write = 1; up_dma_src = 4'h1; up_dma_data = 32'hAAAA_0001;
            end
            if (c == 1) begin
                up_rrsp_valid = 1; up_rrsp_src = 4'h2; up_rrsp_data = 32'hBBBB_0002;
            end
            if (c == 2) begin
                up_dma_valid = 1; up_dma_write = 0; up_dma_src = 4'h3; up_dma_data = 32'hAAAA_0003;
            end
            if (c == 2 || c == 3) begin
                up_rrsp_valid = 1; up_rrsp_src = 4'h4; up_rrsp_data = 32'hBBBB_0004;
            end
            #1;
            if (c == 2)
                chk(up_rrsp_ready === 1'b0, "R4", "rrsp ready on collision", 64'(up_rrsp_ready), 64'(0));
            step();
        end
        chk(fired_kinds.size() == 4, "R3", "ordered entries out", 64'(fired_kinds.size()), 64'(4));
        if (fired_kinds.size() == 4) begin
            chk(fired_kinds[0] == 1, "R3", "first kind (write)", 64'(fired_kinds[0]), 64'(1));
            chk(fired_kinds[1] == 2, "R3", "second kind (response)", 64'(fired_kinds[1]), 64'(2));
            chk(fired_kinds[2] == 0, "R4", "collision: DMA first", 64'(fired_kinds[2]), 64'(0));
            chk(fired_kinds[3] == 2, "R4", "collision: response after", 64'(fired_kinds[3]), 64'(2));
        end
        run_idle(30);

        // R5, R7, R8: fill the shared queue while stalled, feed generic, then release.
        fired_kinds.delete();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            idle_inputs();
            sb_ready = (c >= 10);
            if (c < 10) begin
                up_dma_valid = 1; up_dma_src = SW'(c); up_dma_data = 32'hE000_0000 + 32'(c);
            end
            if (c >= 6 && c < 10) begin
                up_gen_valid = 1; up_gen_src = SW'(c); up_gen_data = 32'hF000_0000 + 32'(c);
            end
            #1;
            step();
        end
        chk(gen_while_full > 0, "R5", "generic accepted with shared queue full", 64'(gen_while_full), 64'(1));
        chk(fired_kinds.size() == 12, "R7", "entries drained", 64'(fired_kinds.size()), 64'(12));
        for (int i = 0; i + 1 < 8 && i + 1 < fired_kinds.size(); i++)
            chk((fired_kinds[i] == 3) != (fired_kinds[i + 1] == 3), "R7", "alternating grant",
                64'(fired_kinds[i + 1]), 64'(fired_kinds[i] == 3 ? 0 : 3));

        // Second random stretch with the model still in lock step (R8 holds covered).
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            random_inputs();
            #1;
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule